// File: doc/BRIEF.md
# Transmitter Delay Compensation Unit

This block places a secondary sample point (SSP) inside each data-phase bit sent by a CAN FD transmitter, so the transmitter can check the bits it reads back from its own bus at high bit rates. At those rates the loop through the transceiver, from the transmit pin back to the receive pin, can take longer than the distance to the normal sample point. Without compensation the transmitter would compare a received bit against the wrong transmitted bit.

The SSP lies a number of controller clock periods after the start of the bit on the transmit side. That number is a loop delay plus an offset. The loop delay is either measured by the block or taken from a fixed setting. The block measures the delay by counting clock periods from a marked falling transmit edge to the next falling receive edge. At every SSP it raises a one-clock strobe and samples the receive line. It then compares the sampled level with the bit that was launched for that SSP and flags any mismatch. A small queue holds the pending sample times and the launched bit values, so the SSP may fall inside a later bit.

The compensation can be off, or it can use the normal sample point. The normal sample point is also used when a filter window rejects a short compensated position. The offset can be given as an absolute count or relative to the normal sample point. Frame sequencing and arbitration belong to the surrounding controller.

Top module: `tdc_unit`

States: the delay meter has `MS_IDLE` (no measurement yet), `MS_RUN` (counting) and `MS_DONE` (result held). Its transitions are:
- `MS_IDLE`→`MS_RUN` on `meas_start`.
- `MS_RUN`→`MS_DONE` on a falling receive edge.
- `MS_RUN`→`MS_RUN` on a new `meas_start`, which restarts the count.
- `MS_DONE`→`MS_RUN` on `meas_start`.

The sample queue has `Q_EMPTY`, `Q_BUSY` and `Q_FULL`. Its transitions are:
- `Q_EMPTY`→`Q_BUSY` on a push.
- `Q_BUSY`→`Q_FULL` when the last slot fills.
- `Q_BUSY`→`Q_EMPTY` when the last entry fires.
- `Q_FULL`→`Q_BUSY` when an entry fires with no push in the same cycle.

## Requirements
- R1: After reset `ssp_strobe` and `bit_err` are 0 and `rx_bit` is 1.
- R2: With `mode` 2'b00 (off) or 2'b11 (both requested, treated as off), the strobe occurs (1+`prop_seg`+`phase_seg1`)×`brp` clock periods after the `bit_start` cycle.
- R3: With `mode` 2'b10 (fixed delay), the strobe occurs `cfg_delay`+offset clock periods after the `bit_start` cycle.
- R4: With `mode` 2'b01 (measured delay), the strobe occurs measured delay + offset clock periods after `bit_start`, and `cfg_delay` has no effect.
- R5: The measured delay is the number of clock periods from the `meas_start` cycle to the first cycle in which `rxd` is 0 after having been 1. Each new `meas_start` replaces the earlier result.
- R6: The measured delay saturates at 2^CNT_W−1 (255 by default).
- R7: In measured mode, when `cfg_filter` is greater than the absolute offset and delay+offset is less than `cfg_filter`, the normal sample point of R2 is used instead.
- R8: The filter has no effect in fixed-delay mode, and has no effect when delay+offset is not below `cfg_filter`.
- R9: With `offset_rel`=1, `cfg_offset` is a two's complement value added to the normal sample point to form the absolute offset. With `offset_rel`=0 it is an unsigned absolute count.
- R10: Each SSP gives exactly one strobe pulse. `rx_bit` takes the `rxd` level of that cycle and changes at no other time. `bit_err` pulses together with the strobe exactly when that level differs from the `txd` value captured with the matching `bit_start`.
- R11: Positions longer than one bit are served in order, with up to QDEPTH (4) outstanding bits, and each compare uses its own launched bit.
- R12: A computed position below 1 is raised to 1 clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; one period is the minimum time quantum |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd | input | 1 | Bit being launched on the transmit pin |
| rxd | input | 1 | Level on the receive pin |
| bit_start | input | 1 | One-cycle pulse in the first cycle of each transmitted data bit |
| meas_start | input | 1 | One-cycle pulse at the marked falling transmit edge that starts a delay measurement |
| mode | input | 2 | 00 off, 01 measured delay, 10 fixed delay, 11 off |
| offset_rel | input | 1 | 1: offset is signed and relative to the normal sample point |
| cfg_delay | input | CNT_W | Fixed loop delay in clock periods |
| cfg_offset | input | CNT_W | Offset in clock periods |
| cfg_filter | input | CNT_W | Filter window in clock periods |
| brp | input | BRP_W | Prescaler: clock periods per time quantum |
| prop_seg | input | SEG_W | Propagation segment in time quanta |
| phase_seg1 | input | SEG_W | Phase segment 1 in time quanta |
| ssp_strobe | output | 1 | One-cycle pulse at each secondary sample point |
| rx_bit | output | 1 | Receive level captured at the last strobe |
| bit_err | output | 1 | One-cycle pulse when the captured level differs from the launched bit |

## Verification
A wrong delay count, position choice or filter decision moves the strobe. It appears at the ports as the `ssp_strobe` pulse landing one or more clock periods away from the expected cycle of the very next data bit. A wrong queue pointer or stale entry pairs the sampled level with another bit's value. That shows up as a spurious or missing `bit_err` on the first strobe after the pairing slips, or as a missing or extra strobe within one SSP delay. A meter stuck in the wrong state leaves the previous measurement in place. That is visible as a stale strobe position in the first measured-mode frame after the new measurement.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    typedef enum logic [1:0] {
        TDC_OFF    = 2'b00,
        TDC_AUTO   = 2'b01,
        TDC_MANUAL = 2'b10,
        TDC_BOTH   = 2'b11
    } tdc_mode_e;

    typedef enum logic [1:0] {
        MS_IDLE = 2'b00,
        MS_RUN  = 2'b01,
        MS_DONE = 2'b10
    } meas_state_e;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'b00,
        Q_BUSY  = 2'b01,
        Q_FULL  = 2'b10
    } queue_state_e;

endpackage

// File: rtl/tdc_delay_meas.sv
module tdc_delay_meas
    import tdc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_start,
    input  logic             rxd,
    output logic [CNT_W-1:0] meas_delay
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    meas_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             rxd_q;
    logic             rx_fall;

    assign rx_fall = rxd_q && !rxd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_IDLE: if (meas_start) state_d = MS_RUN;
            MS_RUN: begin
                if (meas_start)   state_d = MS_RUN;
                else if (rx_fall) state_d = MS_DONE;
            end
            MS_DONE: if (meas_start) state_d = MS_RUN;
            default: state_d = MS_IDLE;
        endcase
    end

    // counter and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            meas_delay <= '0;
            rxd_q      <= 1'b1;
        end else begin
            rxd_q <= rxd;
            if (meas_start) begin
                cnt_q <= CNT_W'(1);
            end else if (state_q == MS_RUN) begin
                if (rx_fall)              meas_delay <= cnt_q;
                else if (cnt_q != CNT_MAX) cnt_q     <= cnt_q + CNT_W'(1);
            end
        end
    end

    // R6
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_RUN && cnt_q == CNT_MAX && !meas_start) |=> (cnt_q == CNT_MAX));

    // R5
    meas_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_RUN && rx_fall && !meas_start) |=> (state_q == MS_DONE));

endmodule

// File: rtl/tdc_ssp_calc.sv
module tdc_ssp_calc
    import tdc_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEG_W = 6,
    parameter int BRP_W = 4,
    parameter int POS_W = 12
) (
    input  logic [1:0]       mode,
    input  logic             offset_rel,
    input  logic [CNT_W-1:0] cfg_delay,
    input  logic [CNT_W-1:0] meas_delay,
    input  logic [CNT_W-1:0] cfg_offset,
    input  logic [CNT_W-1:0] cfg_filter,
    input  logic [BRP_W-1:0] brp,
    input  logic [SEG_W-1:0] prop_seg,
    input  logic [SEG_W-1:0] phase_seg1,
    output logic [POS_W-1:0] ssp_pos
);

    localparam int EW = POS_W + 2;

    tdc_mode_e        m;
    logic [POS_W-1:0] seg_sum, sp_clk;
    logic [EW-1:0]    sp_ext, off_abs, dly_ext, raw, filt_ext, pick;
    logic             comp_on, filt_ok, filter_hit, use_ssp;

    assign m = tdc_mode_e'(mode);

    always_comb begin
        seg_sum  = POS_W'(prop_seg) + POS_W'(phase_seg1) + POS_W'(1);
        sp_clk   = seg_sum * POS_W'(brp);
        sp_ext   = {2'b00, sp_clk};
        filt_ext = {{(EW-CNT_W){1'b0}}, cfg_filter};
        if (offset_rel)
            off_abs = {{(EW-CNT_W){cfg_offset[CNT_W-1]}}, cfg_offset} + sp_ext;
        else
            off_abs = {{(EW-CNT_W){1'b0}}, cfg_offset};

        unique case (m)
            TDC_AUTO: begin
                dly_ext = {{(EW-CNT_W){1'b0}}, meas_delay};
                comp_on = 1'b1;
                filt_ok = 1'b1;
            end
            TDC_MANUAL: begin
                dly_ext = {{(EW-CNT_W){1'b0}}, cfg_delay};
                comp_on = 1'b1;
                filt_ok = 1'b0;
            end
            TDC_OFF, TDC_BOTH: begin
                dly_ext = '0;
                comp_on = 1'b0;
                filt_ok = 1'b0;
            end
            default: begin
                dly_ext = '0;
                comp_on = 1'b0;
                filt_ok = 1'b0;
            end
        endcase

        raw        = dly_ext + off_abs;
        filter_hit = filt_ok && ($signed(filt_ext) > $signed(off_abs))
                             && ($signed(raw) < $signed(filt_ext));
        use_ssp    = comp_on && !filter_hit;
        pick       = use_ssp ? raw : sp_ext;

        if (pick[EW-1] || pick == '0) ssp_pos = POS_W'(1);
        else if (|pick[EW-2:POS_W])   ssp_pos = '1;
        else                          ssp_pos = pick[POS_W-1:0];
    end

endmodule

// File: rtl/tdc_ssp_queue.sv
module tdc_ssp_queue
    import tdc_pkg::*;
#(
    parameter int POS_W = 12,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [POS_W-1:0] push_due,
    input  logic             push_bit,
    input  logic [POS_W-1:0] now,
    output logic             fire,
    output logic             fire_bit
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int QC_W  = $clog2(DEPTH + 1);
    localparam logic [QC_W-1:0] FULL_CNT = QC_W'(DEPTH);

    queue_state_e     state_q, state_d;
    logic [POS_W-1:0] due_q [DEPTH];
    logic             bit_q [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [QC_W-1:0]  count_q, count_d;
    logic             push_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        fire     = (state_q != Q_EMPTY) && (due_q[rd_ptr] == now);
        fire_bit = bit_q[rd_ptr];
        push_ok  = push && ((state_q != Q_FULL) || fire);
        count_d  = count_q + QC_W'(push_ok) - QC_W'(fire);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: if (push_ok) state_d = (count_d == FULL_CNT) ? Q_FULL : Q_BUSY;
            Q_BUSY: begin
                if (count_d == '0)           state_d = Q_EMPTY;
                else if (count_d == FULL_CNT) state_d = Q_FULL;
            end
            Q_FULL: begin
                if (count_d == '0)            state_d = Q_EMPTY;
                else if (count_d != FULL_CNT) state_d = Q_BUSY;
            end
            default: state_d = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count_q <= '0;
        end else begin
            count_q <= count_d;
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (fire)    rd_ptr <= ptr_next(rd_ptr);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                due_q[g] <= '0;
                bit_q[g] <= 1'b1;
            end else if (push_ok && wr_ptr == PTR_W'(g)) begin
                due_q[g] <= push_due;
                bit_q[g] <= push_bit;
            end
        end
    end

    // R11
    no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (state_q != Q_FULL || fire));

    // R11
    pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !push) |=> (count_q == $past(count_q) - QC_W'(1)));

endmodule

// File: rtl/tdc_unit.sv
module tdc_unit
    import tdc_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int SEG_W  = 6,
    parameter int BRP_W  = 4,
    parameter int POS_W  = 12,
    parameter int QDEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txd,
    input  logic             rxd,
    input  logic             bit_start,
    input  logic             meas_start,
    input  logic [1:0]       mode,
    input  logic             offset_rel,
    input  logic [CNT_W-1:0] cfg_delay,
    input  logic [CNT_W-1:0] cfg_offset,
    input  logic [CNT_W-1:0] cfg_filter,
    input  logic [BRP_W-1:0] brp,
    input  logic [SEG_W-1:0] prop_seg,
    input  logic [SEG_W-1:0] phase_seg1,
    output logic             ssp_strobe,
    output logic             rx_bit,
    output logic             bit_err
);

    logic [CNT_W-1:0] meas_delay;
    logic [POS_W-1:0] ssp_pos;
    logic [POS_W-1:0] timer_q;
    logic             fire, fire_bit;

    tdc_delay_meas #(.CNT_W(CNT_W)) meas_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_start (meas_start),
        .rxd        (rxd),
        .meas_delay (meas_delay)
    );

    tdc_ssp_calc #(
        .CNT_W (CNT_W),
        .SEG_W (SEG_W),
        .BRP_W (BRP_W),
        .POS_W (POS_W)
    ) calc_i (
        .mode       (mode),
        .offset_rel (offset_rel),
        .cfg_delay  (cfg_delay),
        .meas_delay (meas_delay),
        .cfg_offset (cfg_offset),
        .cfg_filter (cfg_filter),
        .brp        (brp),
        .prop_seg   (prop_seg),
        .phase_seg1 (phase_seg1),
        .ssp_pos    (ssp_pos)
    );

    tdc_ssp_queue #(.POS_W(POS_W), .DEPTH(QDEPTH)) queue_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (bit_start),
        .push_due (timer_q + ssp_pos),
        .push_bit (txd),
        .now      (timer_q),
        .fire     (fire),
        .fire_bit (fire_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) timer_q <= '0;
        else        timer_q <= timer_q + POS_W'(1);
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ssp_strobe <= 1'b0;
            rx_bit     <= 1'b1;
            bit_err    <= 1'b0;
        end else begin
            ssp_strobe <= fire;
            bit_err    <= fire && (rxd != fire_bit);
            if (fire) rx_bit <= rxd;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ssp_strobe && !bit_err && rx_bit));

    // R10
    err_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> ssp_strobe);

    // R10
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ssp_strobe |-> $stable(rx_bit));

endmodule

// File: tb/tdc_unit_tb_top.sv
module tdc_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txd = 1'b1, rxd = 1'b1, bit_start = 1'b0, meas_start = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       offset_rel = 1'b0;
    logic [7:0] cfg_delay = '0, cfg_offset = '0, cfg_filter = '0;
    logic [3:0] brp = 4'd2;
    logic [5:0] prop_seg = 6'd2, phase_seg1 = 6'd3;
    logic       ssp_strobe, rx_bit, bit_err;

    always #10 clk = ~clk;

    tdc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .txd(txd), .rxd(rxd), .bit_start(bit_start),
        .meas_start(meas_start), .mode(mode), .offset_rel(offset_rel),
        .cfg_delay(cfg_delay), .cfg_offset(cfg_offset), .cfg_filter(cfg_filter),
        .brp(brp), .prop_seg(prop_seg), .phase_seg1(phase_seg1),
        .ssp_strobe(ssp_strobe), .rx_bit(rx_bit), .bit_err(bit_err)
    );

    int   checks = 0, errors = 0, cyc = 0, dly = 1, stray = 0;
    logic tx_hist [16384];
    logic fl_hist [16384];
    int   ev_e   [64];
    logic ev_rx  [64];
    logic ev_err [64];
    int   ev_n = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && ssp_strobe) begin
            if (ev_n < 64) begin
                ev_e[ev_n]   = cyc - 1;
                ev_rx[ev_n]  = rx_bit;
                ev_err[ev_n] = bit_err;
            end
            ev_n = ev_n + 1;
        end
        if (rst_n && bit_err && !ssp_strobe) stray = stray + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic txv, input logic bs, input logic ms, input logic fl);
        @(negedge clk);
        tx_hist[cyc] = txv;
        fl_hist[cyc] = fl;
        txd        = txv;
        bit_start  = bs;
        meas_start = ms;
        rxd        = (cyc >= dly) ? (tx_hist[cyc-dly] ^ fl_hist[cyc-dly]) : 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    function automatic logic rx_at(input int e);
        return (e >= dly) ? (tx_hist[e-dly] ^ fl_hist[e-dly]) : 1'b1;
    endfunction

    function automatic int sp_now();
        return (1 + int'(prop_seg) + int'(phase_seg1)) * int'(brp);
    endfunction

    // expected position from the requirement text (R2, R3, R4, R7, R8, R9, R12)
    function automatic int pos_exp(input int measured);
        int o, d, s;
        o = offset_rel ? (int'($signed(cfg_offset)) + sp_now()) : int'(cfg_offset);
        if (mode == 2'b00 || mode == 2'b11) return sp_now();
        d = (mode == 2'b01) ? measured : int'(cfg_delay);
        s = d + o;
        if (mode == 2'b01 && int'(cfg_filter) > o && s < int'(cfg_filter)) return sp_now();
        if (s < 1) return 1;
        return s;
    endfunction

    task automatic run_frame(input string tag, input int n, input logic [31:0] bits,
                             input logic [31:0] flips, input int bitlen, input int pos);
        int st [32];
        int e;
        logic rx_e;
        idle(dly + 4);
        ev_n = 0;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < bitlen; k++) begin
                drive(bits[i], k == 0, 1'b0, flips[i]);
                if (k == 0) st[i] = cyc;
            end
        end
        idle(pos + 8);
        chk(ev_n == n, {tag, " strobe count"}, ev_n, n);
        for (int i = 0; i < n && i < ev_n; i++) begin
            e    = st[i] + pos;
            rx_e = rx_at(e);
            chk(ev_e[i] == e, {tag, " strobe position"}, ev_e[i] - st[i], pos);
            chk(ev_rx[i] == rx_e, {tag, " rx_bit"}, int'(ev_rx[i]), int'(rx_e));
            chk(ev_err[i] == (rx_e != bits[i]), {tag, " bit_err"},
                int'(ev_err[i]), int'(rx_e != bits[i]));
        end
    endtask

    task automatic measure(input int d);
        dly = d;
        idle(d + 4);
        drive(1'b0, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < d + 3; i++) drive(1'b0, 1'b0, 1'b0, 1'b0);
        idle(d + 4);
    endtask

    task automatic set_timing(input int b, input int p, input int p1);
        brp = 4'(b); prop_seg = 6'(p); phase_seg1 = 6'(p1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ssp_strobe == 1'b0, "R1 strobe", int'(ssp_strobe), 0);
        chk(bit_err == 1'b0, "R1 bit_err", int'(bit_err), 0);
        chk(rx_bit == 1'b1, "R1 rx_bit", int'(rx_bit), 1);
    endtask

    task automatic t_off();
        set_timing(2, 2, 3); offset_rel = 0; cfg_delay = 8'd7; cfg_offset = 8'd6;
        dly = 7; mode = 2'b00;
        chk(pos_exp(0) == 12, "R2 formula", pos_exp(0), 12);
        run_frame("R2 off", 4, 32'b0110, 32'b0, 16, 12);
        mode = 2'b11;
        run_frame("R2 both", 3, 32'b101, 32'b0, 16, 12);
    endtask

    task automatic t_manual();
        set_timing(2, 2, 3); offset_rel = 0; mode = 2'b10;
        cfg_delay = 8'd7; cfg_offset = 8'd6; cfg_filter = 8'd0; dly = 7;
        run_frame("R3 manual", 4, 32'b1001, 32'b0, 16, 13);
    endtask

    task automatic t_auto();
        set_timing(2, 2, 3); offset_rel = 0; mode = 2'b01;
        cfg_delay = 8'd3; cfg_offset = 8'd6; cfg_filter = 8'd0;
        measure(9);
        run_frame("R4 measured", 4, 32'b0101, 32'b0, 16, pos_exp(9));
        measure(5);
        run_frame("R5 remeasure", 3, 32'b011, 32'b0, 16, 11);
    endtask

    task automatic t_filter();
        set_timing(2, 2, 3); offset_rel = 0; mode = 2'b01;
        cfg_offset = 8'd6; measure(9);
        cfg_filter = 8'd20;
        run_frame("R7 filter hit", 3, 32'b110, 32'b0, 16, 12);
        cfg_filter = 8'd14;
        run_frame("R8 filter miss", 3, 32'b010, 32'b0, 16, 15);
        mode = 2'b10; cfg_delay = 8'd7; cfg_filter = 8'd20; dly = 7;
        run_frame("R8 manual filter", 3, 32'b100, 32'b0, 16, 13);
        cfg_filter = 8'd0;
    endtask

    task automatic t_relative();
        set_timing(2, 2, 3); mode = 2'b10; offset_rel = 1; cfg_delay = 8'd7; dly = 7;
        cfg_offset = 8'd2;
        run_frame("R9 relative plus", 3, 32'b011, 32'b0, 16, 21);
        cfg_offset = 8'hFD;
        run_frame("R9 relative minus", 3, 32'b110, 32'b0, 16, 16);
    endtask

    task automatic t_clamp();
        set_timing(2, 2, 3); mode = 2'b10; offset_rel = 1; cfg_delay = 8'd0; dly = 1;
        cfg_offset = 8'hEC;
        chk(pos_exp(0) == 1, "R12 formula", pos_exp(0), 1);
        run_frame("R12 clamp", 3, 32'b010, 32'b0, 16, 1);
        offset_rel = 0;
    endtask

    task automatic t_errors();
        set_timing(2, 2, 3); mode = 2'b10; offset_rel = 0;
        cfg_delay = 8'd7; cfg_offset = 8'd6; dly = 7;
        run_frame("R10 errors", 5, 32'b11010, 32'b00101, 16, 13);
        chk(ev_err[0] == 1'b1 && ev_err[1] == 1'b0, "R10 flagged bits",
            int'(ev_err[0]) * 2 + int'(ev_err[1]), 2);
    endtask

    task automatic t_late();
        set_timing(2, 2, 3); mode = 2'b10; offset_rel = 0;
        cfg_delay = 8'd20; cfg_offset = 8'd10; dly = 20;
        run_frame("R11 late", 6, 32'b101101, 32'b0, 16, 30);
    endtask

    task automatic t_saturate();
        set_timing(8, 10, 10); mode = 2'b01; offset_rel = 0;
        cfg_offset = 8'd4; cfg_filter = 8'd0; cfg_delay = 8'd9;
        measure(300);
        dly = 250;
        run_frame("R6 saturated", 3, 32'b010, 32'b0, 248, 259);
    endtask

    initial begin
        for (int i = 0; i < 16384; i++) begin
            tx_hist[i] = 1'b1;
            fl_hist[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_off();
        t_manual();
        t_auto();
        t_filter();
        t_relative();
        t_clamp();
        t_errors();
        t_late();
        t_saturate();
        chk(stray == 0, "R10 no error without strobe", stray, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule